// File: doc/BRIEF.md
# Local-to-VME Window Decoder

This block sits between a local processor bus and a VMEbus master. Each local bus address presented to it is classified into a VMEbus access window. The block reports whether any window claims the address, which VMEbus address space the access targets, whether the data width is forced to 16 bits, and whether a write may be posted. When no window claims the address, a miss output is raised so that surrounding bus logic can end the cycle with an error or a time-out.

The block has a number of programmable range segments, four by default. Each segment has a start register and an end register that cover the upper address half at 64 KB granularity, plus attribute bits. Two fixed I/O windows sit alongside the segments. One is a short-I/O window at the top of the map. The other splits into an A24 part and an A32 part. All configuration is loaded through a single-cycle register write port. A decode is requested with an address-valid strobe, and its registered result appears one clock later.

Top module: `lb_vme_window_dec`

## Requirements
- R1: A programmable segment claims an address when its enable bit is set and address bits 31..16 lie between its start and end registers, with both bounds inclusive. Register select 2*s writes segment s: data bits 15..0 go to start and bits 31..16 go to end.
- R2: After reset every start, end, attribute and I/O control bit is 0. No segment and no I/O window responds, and resValid, hit and miss are all 0.
- R3: A segment whose enable bit is 0 never claims an address, whatever its range holds.
- R4: Register select 2*s+1 writes the attributes of segment s: bit0 is enable, bit1 is write-post, bit2 forces D16, and bit3 selects A24 space. When bit3 is clear the segment targets A32. The space output is encoded as 0 for A16, 1 for A24 and 2 for A32.
- R5: The short-I/O window claims addresses FFFF0000 to FFFFFFFF with space A16. It is controlled at register select 2*NUM_SEG: bit0 enables it, bit1 allows write-post, and bit2 forces D16 (otherwise the width is D32).
- R6: The second I/O window claims F0000000 to F0FFFFFF as A24 and F1000000 to FF7FFFFF as A32. Its width is always D16. It is enabled by bit3 and allows write-post by bit4 of the I/O control register.
- R7: When several windows claim one address, the lowest-numbered segment wins, then the short-I/O window, then the second I/O window. multiHit is set whenever more than one window claims the address.
- R8: resValid pulses exactly in the cycle after each addrValid cycle. The result outputs change only after an addrValid cycle and otherwise hold their last values.
- R9: A register write affects only decodes strobed in later cycles. A decode strobed in the same cycle as a write uses the old configuration. Register selects above 2*NUM_SEG are ignored.
- R10: When nothing claims the address, miss is 1 and hit, multiHit, d16 and wpost are 0, with space reported as 0. For a valid result, hit and miss are never both set or both clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Configuration write strobe |
| wrSel | input | SEL_W | Configuration register select |
| wrData | input | 32 | Configuration write data |
| addrValid | input | 1 | Decode request strobe |
| addr | input | 32 | Local bus address to decode |
| resValid | output | 1 | Result valid pulse, one cycle after addrValid |
| hit | output | 1 | A window claimed the address |
| miss | output | 1 | No window claimed the address |
| multiHit | output | 1 | More than one window claimed the address |
| space | output | 2 | Target space: 0 A16, 1 A24, 2 A32 |
| d16 | output | 1 | Transfer forced to 16 bits |
| wpost | output | 1 | Posted write allowed |

## Verification
The case that matters is a configuration write and a decode strobe falling in the same clock. The decode must be resolved against the configuration as it stood before the write, and only the next decode may see the new setting. The bench provokes this collision in directed form, by enabling a segment in the very cycle its address is decoded. It also lets the random phase issue writes and decodes together freely. A behavioural model that updates its configuration only after computing the decode judges every cycle, and a directed pair of decodes confirms the miss-then-hit sequence.

// File: rtl/lvwd_pkg.sv
`timescale 1ns/1ps
package lvwd_pkg;

  typedef enum logic [1:0] {
    SPACE_A16 = 2'd0,
    SPACE_A24 = 2'd1,
    SPACE_A32 = 2'd2
  } spaceT;

  // attribute bits of one programmable segment
  typedef struct packed {
    logic a24;
    logic d16;
    logic wpost;
    logic enable;
  } segAttrT;

  // fixed I/O window control bits
  typedef struct packed {
    logic io2Wp;
    logic io2En;
    logic io1D16;
    logic io1Wp;
    logic io1En;
  } ioCtrlT;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;
    logic rangeWr;
    logic attrWr;
    logic ioWr;
  } strobeT;

  // one decoded result
  typedef struct packed {
    logic  hit;
    logic  miss;
    logic  multiHit;
    logic  d16;
    logic  wpost;
    spaceT space;
  } decResT;

endpackage

// File: rtl/lvwd_ctrl.sv
`timescale 1ns/1ps
module lvwd_ctrl
  import lvwd_pkg::*;
#(
  parameter int NUM_SEG = 4,
  parameter int SEL_W   = 4
) (
  input  logic               wrEn,
  input  logic [SEL_W-1:0]   wrSel,
  input  logic               addrValid,
  output strobeT             strobes,
  output logic [NUM_SEG-1:0] segSel
);

  localparam int IO_SEL = 2 * NUM_SEG;

  logic inSegArea;
  logic [SEL_W-1:0] segIdx;

  assign inSegArea = (int'(wrSel) < IO_SEL);
  assign segIdx    = wrSel >> 1;

  always_comb begin
    segSel = '0;
    for (int i = 0; i < NUM_SEG; i++) begin
      segSel[i] = inSegArea && (int'(segIdx) == i);
    end
  end

  always_comb begin
    strobes         = '0;
    strobes.capture = addrValid;
    strobes.rangeWr = wrEn && inSegArea && !wrSel[0];
    strobes.attrWr  = wrEn && inSegArea && wrSel[0];
    strobes.ioWr    = wrEn && (int'(wrSel) == IO_SEL);
  end

endmodule

// File: rtl/lvwd_seg_cmp.sv
`timescale 1ns/1ps
module lvwd_seg_cmp #(
  parameter int CMP_W = 16
) (
  input  logic [CMP_W-1:0] addrHi,
  input  logic [CMP_W-1:0] lowBound,
  input  logic [CMP_W-1:0] highBound,
  input  logic             enable,
  output logic             match
);

  logic aboveLow;
  logic belowHigh;

  assign aboveLow  = (addrHi >= lowBound);
  assign belowHigh = (addrHi <= highBound);
  assign match     = enable && aboveLow && belowHigh;

endmodule

// File: rtl/lvwd_datapath.sv
`timescale 1ns/1ps
module lvwd_datapath
  import lvwd_pkg::*;
#(
  parameter int NUM_SEG = 4,
  parameter int ADDR_W  = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  strobeT             strobes,
  input  logic [NUM_SEG-1:0] segSel,
  input  logic [31:0]        wrData,
  input  logic [ADDR_W-1:0]  addr,
  output logic               resValid,
  output decResT             result
);

  localparam int CMP_W = 16;
  localparam int HI_LSB = ADDR_W - CMP_W;
  localparam int NUM_WIN = NUM_SEG + 2;

  logic [CMP_W-1:0] startReg [NUM_SEG];
  logic [CMP_W-1:0] endReg   [NUM_SEG];
  segAttrT          attrReg  [NUM_SEG];
  ioCtrlT           ioReg;

  logic [CMP_W-1:0]   addrHi;
  logic [NUM_SEG-1:0] segHit;
  logic io1Hit, io2A24, io2A32, io2Hit;
  logic [NUM_WIN-1:0] allHits;
  decResT nxtRes;

  assign addrHi = addr[ADDR_W-1:HI_LSB];

  // per-segment configuration and comparison
  for (genvar g = 0; g < NUM_SEG; g++) begin : gSeg
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        startReg[g] <= '0;
        endReg[g]   <= '0;
        attrReg[g]  <= '0;
      end else begin
        if (strobes.rangeWr && segSel[g]) begin
          startReg[g] <= wrData[15:0];
          endReg[g]   <= wrData[31:16];
        end
        if (strobes.attrWr && segSel[g]) begin
          attrReg[g] <= segAttrT'(wrData[3:0]);
        end
      end
    end

    lvwd_seg_cmp #(.CMP_W(CMP_W)) uCmp (
      .addrHi   (addrHi),
      .lowBound (startReg[g]),
      .highBound(endReg[g]),
      .enable   (attrReg[g].enable),
      .match    (segHit[g])
    );
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ioReg <= '0;
    end else if (strobes.ioWr) begin
      ioReg <= ioCtrlT'(wrData[4:0]);
    end
  end

  // fixed I/O windows
  assign io1Hit = ioReg.io1En && (addrHi == 16'hFFFF);
  assign io2A24 = (addr[ADDR_W-1:ADDR_W-8] == 8'hF0);
  assign io2A32 = ((addr[ADDR_W-1:ADDR_W-8] >= 8'hF1) && (addr[ADDR_W-1:ADDR_W-8] <= 8'hFE))
                || (addr[ADDR_W-1:ADDR_W-9] == 9'h1FE);
  assign io2Hit = ioReg.io2En && (io2A24 || io2A32);

  assign allHits = {io2Hit, io1Hit, segHit};

  // priority resolve: later assignments win, so walk from lowest to highest priority
  always_comb begin
    nxtRes = '0;
    nxtRes.space = SPACE_A16;
    if (io2Hit) begin
      nxtRes.space = io2A24 ? SPACE_A24 : SPACE_A32;
      nxtRes.d16   = 1'b1;
      nxtRes.wpost = ioReg.io2Wp;
    end
    if (io1Hit) begin
      nxtRes.space = SPACE_A16;
      nxtRes.d16   = ioReg.io1D16;
      nxtRes.wpost = ioReg.io1Wp;
    end
    for (int i = NUM_SEG - 1; i >= 0; i--) begin
      if (segHit[i]) begin
        nxtRes.space = attrReg[i].a24 ? SPACE_A24 : SPACE_A32;
        nxtRes.d16   = attrReg[i].d16;
        nxtRes.wpost = attrReg[i].wpost;
      end
    end
    nxtRes.hit      = |allHits;
    nxtRes.miss     = ~|allHits;
    nxtRes.multiHit = ($countones(allHits) > 1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resValid <= 1'b0;
      result   <= '0;
    end else begin
      resValid <= strobes.capture;
      if (strobes.capture) begin
        result <= nxtRes;
      end
    end
  end

endmodule

// File: rtl/lb_vme_window_dec.sv
`timescale 1ns/1ps
module lb_vme_window_dec
  import lvwd_pkg::*;
#(
  parameter  int NUM_SEG = 4,
  localparam int SEL_W   = $clog2(2 * NUM_SEG + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [SEL_W-1:0] wrSel,
  input  logic [31:0]      wrData,
  input  logic             addrValid,
  input  logic [31:0]      addr,
  output logic             resValid,
  output logic             hit,
  output logic             miss,
  output logic             multiHit,
  output logic [1:0]       space,
  output logic             d16,
  output logic             wpost
);

  strobeT             strobes;
  logic [NUM_SEG-1:0] segSel;
  decResT             result;

  lvwd_ctrl #(.NUM_SEG(NUM_SEG), .SEL_W(SEL_W)) uCtrl (
    .wrEn     (wrEn),
    .wrSel    (wrSel),
    .addrValid(addrValid),
    .strobes  (strobes),
    .segSel   (segSel)
  );

  lvwd_datapath #(.NUM_SEG(NUM_SEG), .ADDR_W(32)) uDp (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .segSel  (segSel),
    .wrData  (wrData),
    .addr    (addr),
    .resValid(resValid),
    .result  (result)
  );

  assign hit      = result.hit;
  assign miss     = result.miss;
  assign multiHit = result.multiHit;
  assign space    = result.space;
  assign d16      = result.d16;
  assign wpost    = result.wpost;

endmodule

// File: rtl/lvwd_checker.sv
`timescale 1ns/1ps
module lvwd_checker (
  input logic       clk,
  input logic       rstN,
  input logic       addrValid,
  input logic       resValid,
  input logic       hit,
  input logic       miss,
  input logic       multiHit,
  input logic [1:0] space,
  input logic       d16,
  input logic       wpost
);

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    addrValid |=> resValid); // R8

  AST_VALID_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    !addrValid |=> !resValid); // R8

  AST_RESULT_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    !addrValid |=> ($stable(hit) && $stable(miss) && $stable(space) && $stable(d16) && $stable(wpost))); // R8

  AST_HIT_XOR_MISS: assert property (@(posedge clk) disable iff (!rstN)
    resValid |-> (hit ^ miss)); // R10

  AST_MISS_CLEAN: assert property (@(posedge clk) disable iff (!rstN)
    miss |-> (!d16 && !wpost && !multiHit && space == 2'd0)); // R10

  AST_MULTI_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rstN)
    multiHit |-> hit); // R7

endmodule

bind lb_vme_window_dec lvwd_checker uChk (
  .clk      (clk),
  .rstN     (rstN),
  .addrValid(addrValid),
  .resValid (resValid),
  .hit      (hit),
  .miss     (miss),
  .multiHit (multiHit),
  .space    (space),
  .d16      (d16),
  .wpost    (wpost)
);

// File: tb/tb_lb_vme_window_dec.sv
`timescale 1ns/1ps
module tb_lb_vme_window_dec;

  localparam int NSEG = 4;
  localparam int SW   = $clog2(2 * NSEG + 1);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic [SW-1:0] wrSel = '0;
  logic [31:0] wrData = '0;
  logic addrValid = 1'b0;
  logic [31:0] addr = '0;
  logic resValid, hit, miss, multiHit, d16, wpost;
  logic [1:0] space;

  always #2 clk = ~clk;

  lb_vme_window_dec #(.NUM_SEG(NSEG)) dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .addrValid(addrValid), .addr(addr), .resValid(resValid), .hit(hit),
    .miss(miss), .multiHit(multiHit), .space(space), .d16(d16), .wpost(wpost)
  );

  int checks = 0;
  int errors = 0;
  string curTag = "R2";

  // behavioural reference state
  int mLo [NSEG];
  int mHi [NSEG];
  int mAt [NSEG];
  int mIo;
  int eValid, eHit, eMiss, eMulti, eD16, eWp, eSpace;

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic void modelDecode(logic [31:0] a);
    int top, nHits, won;
    top = int'(a[31:16]);
    nHits = 0; won = 0;
    eD16 = 0; eWp = 0; eSpace = 0;
    for (int i = 0; i < NSEG; i++) begin
      if ((mAt[i] & 1) != 0 && top >= mLo[i] && top <= mHi[i]) begin
        nHits++;
        if (!won) begin
          won = 1;
          eSpace = ((mAt[i] >> 3) & 1) ? 1 : 2;
          eD16 = (mAt[i] >> 2) & 1;
          eWp = (mAt[i] >> 1) & 1;
        end
      end
    end
    if ((mIo & 1) != 0 && top == 'hFFFF) begin
      nHits++;
      if (!won) begin
        won = 1; eSpace = 0; eD16 = (mIo >> 2) & 1; eWp = (mIo >> 1) & 1;
      end
    end
    if (((mIo >> 3) & 1) != 0 && a >= 32'hF000_0000 && a <= 32'hFF7F_FFFF) begin
      nHits++;
      if (!won) begin
        won = 1; eSpace = (a <= 32'hF0FF_FFFF) ? 1 : 2; eD16 = 1; eWp = (mIo >> 4) & 1;
      end
    end
    eHit = (nHits > 0);
    eMiss = (nHits == 0);
    eMulti = (nHits > 1);
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NSEG; i++) begin mLo[i] = 0; mHi[i] = 0; mAt[i] = 0; end
      mIo = 0;
      eValid = 0; eHit = 0; eMiss = 0; eMulti = 0; eD16 = 0; eWp = 0; eSpace = 0;
    end else begin
      eValid = addrValid;
      if (addrValid) modelDecode(addr);  // old configuration first (R9)
      if (wrEn) begin
        if (int'(wrSel) < 2 * NSEG) begin
          if (wrSel[0]) mAt[wrSel >> 1] = int'(wrData[3:0]);
          else begin
            mLo[wrSel >> 1] = int'(wrData[15:0]);
            mHi[wrSel >> 1] = int'(wrData[31:16]);
          end
        end else if (int'(wrSel) == 2 * NSEG) begin
          mIo = int'(wrData[4:0]);
        end
      end
    end
  end

  // compare against model on every cycle, away from the active edge
  always @(negedge clk) begin
    if (rstN) begin
      chk({curTag, " resValid"}, resValid, eValid);
      chk({curTag, " hit"}, hit, eHit);
      chk({curTag, " miss"}, miss, eMiss);
      chk({curTag, " multiHit"}, multiHit, eMulti);
      chk({curTag, " space"}, space, eSpace);
      chk({curTag, " d16"}, d16, eD16);
      chk({curTag, " wpost"}, wpost, eWp);
    end
  end

  task automatic wrCfg(int sel, logic [31:0] data);
    @(negedge clk);
    wrEn = 1'b1; wrSel = SW'(sel); wrData = data;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic decodeAt(logic [31:0] a);
    @(negedge clk);
    addrValid = 1'b1; addr = a;
    @(negedge clk);
    addrValid = 1'b0;
  endtask

  task automatic expectRes(string tag, int h, int sp, int wd, int wp, int mh);
    chk({tag, " hit"}, hit, h);
    chk({tag, " miss"}, miss, !h);
    chk({tag, " space"}, space, sp);
    chk({tag, " d16"}, d16, wd);
    chk({tag, " wpost"}, wpost, wp);
    chk({tag, " multiHit"}, multiHit, mh);
  endtask

  bit done = 0;
  initial begin
    #(4 * 100000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    curTag = "R2";
    chk("R2 resValid", resValid, 0);
    chk("R2 hit", hit, 0);
    chk("R2 miss", miss, 0);
    decodeAt(32'h0000_0000);
    expectRes("R2 reset cfg", 0, 0, 0, 0, 0);
    decodeAt(32'hFFFF_0000);
    expectRes("R2 io off", 0, 0, 0, 0, 0);

    curTag = "R1";
    wrCfg(0, {16'h1FFF, 16'h1000});
    wrCfg(1, 32'h3);              // enable + wpost, A32, D32
    decodeAt(32'h1000_0000);
    expectRes("R1 low bound", 1, 2, 0, 1, 0);
    decodeAt(32'h1FFF_FFFF);
    expectRes("R1 high bound", 1, 2, 0, 1, 0);
    decodeAt(32'h0FFF_FFFF);
    expectRes("R10 below", 0, 0, 0, 0, 0);
    decodeAt(32'h2000_0000);
    expectRes("R10 above", 0, 0, 0, 0, 0);

    curTag = "R4";
    wrCfg(2, {16'h4000, 16'h4000});
    wrCfg(3, 32'hD);              // enable, d16, a24
    decodeAt(32'h4000_1234);
    expectRes("R4 attrs", 1, 1, 1, 0, 0);

    curTag = "R3";
    wrCfg(4, {16'h5FFF, 16'h5000});
    wrCfg(5, 32'hE);              // everything but enable
    decodeAt(32'h5800_0000);
    expectRes("R3 disabled", 0, 0, 0, 0, 0);

    curTag = "R5";
    wrCfg(2 * NSEG, 32'h1F);
    decodeAt(32'hFFFF_1234);
    expectRes("R5 short io", 1, 0, 1, 1, 0);
    wrCfg(2 * NSEG, 32'h19);      // io1 en, D32, no wp; io2 en+wp
    decodeAt(32'hFFFF_0000);
    expectRes("R5 d32", 1, 0, 0, 0, 0);

    curTag = "R6";
    decodeAt(32'hF012_3456);
    expectRes("R6 a24", 1, 1, 1, 1, 0);
    decodeAt(32'hF100_0000);
    expectRes("R6 a32 low", 1, 2, 1, 1, 0);
    decodeAt(32'hFF7F_FFFF);
    expectRes("R6 a32 high", 1, 2, 1, 1, 0);
    decodeAt(32'hFF80_0000);
    expectRes("R6 gap", 0, 0, 0, 0, 0);

    curTag = "R7";
    wrCfg(6, {16'hF0FF, 16'hF000});
    wrCfg(7, 32'h1);
    decodeAt(32'hF000_1000);
    expectRes("R7 seg over io2", 1, 2, 0, 0, 1);
    wrCfg(6, {16'hFFFF, 16'hFFFF});
    decodeAt(32'hFFFF_8000);
    expectRes("R7 seg over io1", 1, 2, 0, 0, 1);
    wrCfg(7, 32'h0);

    curTag = "R9";
    wrCfg(6, {16'h3000, 16'h3000});
    @(negedge clk);
    wrEn = 1'b1; wrSel = SW'(7); wrData = 32'h3;
    addrValid = 1'b1; addr = 32'h3000_0000;
    @(negedge clk);
    wrEn = 1'b0; addrValid = 1'b0;
    expectRes("R9 old cfg", 0, 0, 0, 0, 0);
    decodeAt(32'h3000_0000);
    expectRes("R9 new cfg", 1, 2, 0, 1, 0);
    wrCfg(2 * NSEG + 1, 32'h0);   // out-of-range select ignored
    decodeAt(32'hFFFF_0000);
    expectRes("R9 ignored sel", 1, 0, 0, 0, 0);

    curTag = "R8";
    repeat (3) @(negedge clk);
    expectRes("R8 hold", 1, 0, 0, 0, 0);
    chk("R8 no pulse", resValid, 0);

    // random mix judged by the model each cycle
    curTag = "R9 mix";
    for (int n = 0; n < 2000; n++) begin
      @(negedge clk);
      wrEn = ($urandom % 4) == 0;
      wrSel = SW'($urandom % (2 * NSEG + 2));
      wrData = {4'hF, 12'($urandom), 4'hF, 12'($urandom)};
      if ($urandom % 2) wrData[31:16] = wrData[15:0] + 16'($urandom % 4096);
      addrValid = ($urandom % 3) != 0;
      case ($urandom % 4)
        0: addr = {4'hF, 28'($urandom)};
        1: addr = {16'hFFFF, 16'($urandom)};
        2: addr = {8'hF0, 24'($urandom)};
        default: addr = $urandom;
      endcase
    end
    @(negedge clk);
    wrEn = 1'b0; addrValid = 1'b0;
    repeat (2) @(negedge clk);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule